// File: doc/BRIEF.md
# Dual-Channel Converter Register Controller

This block holds the digital state behind a two-channel, 12-bit voltage converter. A serial front end hands it a complete 16-bit command word together with a load strobe that is high for one cycle. The block decodes the word's four upper control bits, updates the registers they select, and drives the resulting output codes and power-down modes to the analog side.

Each channel has two data stages. The first is a staging (input) register. The second is the output register, whose value the converter actually uses. Commands can fill a staging register only, fill both stages together, or move every staging value into its output register at once. A separate kind of command puts a channel into one of three power-down states, or takes it out again.

An active-low clear input zeroes every register at once, with no clock needed. Codes are straight binary: 0x000 is zero scale and 0xFFF is full scale minus one LSB.

Top module: `dac_dual_regctl`

## Requirements
- R1: While `clr_n` is low, both codes and both power-down modes read zero. A falling `clr_n` forces them to zero without waiting for a clock edge.
- R2: A strobe sampled while `clr_n` is low has no effect. A word presented while `cmd_valid` is low also has no effect. After `clr_n` returns high, the first strobe is applied normally.
- R3: Operation bits [15:14] = 00 with bit 12 = 0 loads bits [11:0] into the addressed channel's staging register only. No output code changes.
- R4: Operation 01 with bit 12 = 0 loads bits [11:0] into both the staging register and the output register of the addressed channel. The other channel is left unchanged.
- R5: Operation 10 with bit 12 = 0 copies both staging registers into their output registers and ignores bits [11:0].
- R6: Operation 11 with bit 12 = 0 loads bits [11:0] into the addressed channel's staging and output registers. In the same cycle, the other channel's output register takes that channel's staging value.
- R7: Bit 13 addresses the channel: 0 selects A, 1 selects B. At most one staging register takes new data per command.
- R8: When bit 12 = 1, bits [11:10] set the addressed channel's power-down mode: 00 normal, 01 1 kΩ to ground, 10 100 kΩ to ground, 11 high impedance. No code register changes.
- R9: When bit 12 = 1 and operation bits [15:14] = 11, the power-down mode from bits [11:10] is applied to both channels.
- R10: A normal-mode command that loads data into a channel (operations 00, 01 and 11) returns that channel's power-down mode to 00. Operation 10 leaves both modes as they are.
- R11: A code is applied in the cycle after the strobe is sampled, and full scale 0xFFF passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; registers update on its rising edge |
| clr_n | input | 1 | Active-low asynchronous clear of all state |
| cmd_valid | input | 1 | Load strobe, one cycle per command |
| cmd_word | input | 16 | Command: [15:14] operation, [13] channel, [12] power-down, [11:0] data |
| code_a | output | 12 | Output code of channel A |
| code_b | output | 12 | Output code of channel B |
| pd_a | output | 2 | Power-down mode of channel A |
| pd_b | output | 2 | Power-down mode of channel B |

## Verification
The clocked assertions assume two things about the inputs. First, `cmd_word` is steady for the whole cycle in which `cmd_valid` is high. Second, `clr_n` rises away from the rising clock edge, so the first cycle after clear begins with a clean register state. The bench meets both conditions by changing every input only on the falling clock edge and by holding the word constant for the full strobe cycle. The clear-held-low case is also driven on a falling edge. This lets the strobe-while-clear case be tested without the assertions ever evaluating a command that began during clear.

// File: rtl/dacreg_pkg.sv
package dacreg_pkg;

  localparam int CMD_W   = 16;
  localparam int DATA_W  = 12;
  localparam int NCH     = 2;
  localparam int PD_W    = 2;
  localparam int PD_LSB  = DATA_W - PD_W;

  typedef enum logic [1:0] {
    OP_STAGE     = 2'b00,
    OP_STAGE_OUT = 2'b01,
    OP_COPY      = 2'b10,
    OP_BROADCAST = 2'b11
  } op_e;

  typedef enum logic [PD_W-1:0] {
    PD_ACTIVE = 2'b00,
    PD_R1K    = 2'b01,
    PD_R100K  = 2'b10,
    PD_FLOAT  = 2'b11
  } pd_e;

  typedef struct packed {
    op_e               op;
    logic              chan;
    logic              pd_mode;
    logic [DATA_W-1:0] data;
  } cmd_t;

  function automatic cmd_t unpack_cmd(input logic [CMD_W-1:0] w);
    cmd_t c;
    c.op      = op_e'(w[CMD_W-1 -: 2]);
    c.chan    = w[CMD_W-3];
    c.pd_mode = w[CMD_W-4];
    c.data    = w[DATA_W-1:0];
    return c;
  endfunction

  function automatic logic [PD_W-1:0] pd_field(input logic [DATA_W-1:0] d);
    return d[DATA_W-1 -: PD_W];
  endfunction

  function automatic logic op_loads_data(input op_e op);
    return op != OP_COPY;
  endfunction

  function automatic logic op_drives_out(input op_e op);
    return op == OP_STAGE_OUT || op == OP_BROADCAST;
  endfunction

endpackage

// File: rtl/dacreg_decode.sv
module dacreg_decode
  import dacreg_pkg::*;
(
  input  logic                 cmd_valid,
  input  logic [CMD_W-1:0]     cmd_word,
  output logic [NCH-1:0]       stage_we,
  output logic [NCH-1:0]       out_we,
  output logic [NCH-1:0]       out_from_stage,
  output logic [NCH-1:0]       pd_we,
  output logic [NCH-1:0]       pd_wake,
  output logic [DATA_W-1:0]    data,
  output logic [PD_W-1:0]      pd_val
);

  cmd_t cmd;
  logic normal_cmd;
  logic power_cmd;

  always_comb begin
    cmd        = unpack_cmd(cmd_word);
    normal_cmd = cmd_valid && !cmd.pd_mode;
    power_cmd  = cmd_valid &&  cmd.pd_mode;
    data       = cmd.data;
    pd_val     = pd_field(cmd.data);
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit;
    assign hit = (cmd.chan == i[0]);

    assign stage_we[i]       = normal_cmd && hit && op_loads_data(cmd.op);
    assign out_we[i]         = normal_cmd &&
                               ((hit && op_drives_out(cmd.op)) ||
                                cmd.op == OP_COPY || cmd.op == OP_BROADCAST);
    assign out_from_stage[i] = (cmd.op == OP_COPY) ||
                               (cmd.op == OP_BROADCAST && !hit);
    assign pd_we[i]          = power_cmd && (hit || cmd.op == OP_BROADCAST);
    assign pd_wake[i]        = stage_we[i];
  end

  // R7: a single command never loads new data into both staging registers
  always_comb begin
    if (cmd_valid) begin
      a_r7_single_target: assert ($onehot0(stage_we));
    end
  end

endmodule

// File: rtl/dacreg_channel.sv
module dacreg_channel
  import dacreg_pkg::*;
(
  input  logic              clk,
  input  logic              clr_n,
  input  logic              stage_we,
  input  logic              out_we,
  input  logic              out_from_stage,
  input  logic              pd_we,
  input  logic              pd_wake,
  input  logic [DATA_W-1:0] data,
  input  logic [PD_W-1:0]   pd_val,
  output logic [DATA_W-1:0] stage_q,
  output logic [DATA_W-1:0] out_q,
  output logic [PD_W-1:0]   pd_q
);

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      stage_q <= '0;
    end else if (stage_we) begin
      stage_q <= data;
    end
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      out_q <= '0;
    end else if (out_we) begin
      out_q <= out_from_stage ? stage_q : data;
    end
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      pd_q <= PD_ACTIVE;
    end else if (pd_we) begin
      pd_q <= pd_val;
    end else if (pd_wake) begin
      pd_q <= PD_ACTIVE;
    end
  end

  // R1: clear holds every register at zero
  a_r1_clear_zero: assert property (@(posedge clk)
    !clr_n |-> (stage_q == '0 && out_q == '0 && pd_q == '0));

  // R3: output code holds unless an output write is requested
  a_r3_out_hold: assert property (@(posedge clk) disable iff (!clr_n)
    !out_we |=> $stable(out_q));

  // R8: staging register holds unless a data load is requested
  a_r8_stage_hold: assert property (@(posedge clk) disable iff (!clr_n)
    !stage_we |=> $stable(stage_q));

  // R10: power-down mode moves only on a mode write or a data load
  a_r10_pd_hold: assert property (@(posedge clk) disable iff (!clr_n)
    !(pd_we || pd_wake) |=> $stable(pd_q));

  // R10: a data load without a mode write returns the channel to normal
  a_r10_wake: assert property (@(posedge clk) disable iff (!clr_n)
    (pd_wake && !pd_we) |=> (pd_q == PD_ACTIVE));

endmodule

// File: rtl/dac_dual_regctl.sv
module dac_dual_regctl
  import dacreg_pkg::*;
(
  input  logic              clk,
  input  logic              clr_n,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_word,
  output logic [DATA_W-1:0] code_a,
  output logic [DATA_W-1:0] code_b,
  output logic [PD_W-1:0]   pd_a,
  output logic [PD_W-1:0]   pd_b
);

  logic [NCH-1:0]    stage_we;
  logic [NCH-1:0]    out_we;
  logic [NCH-1:0]    out_from_stage;
  logic [NCH-1:0]    pd_we;
  logic [NCH-1:0]    pd_wake;
  logic [DATA_W-1:0] data;
  logic [PD_W-1:0]   pd_val;

  logic [DATA_W-1:0] stage_q [NCH];
  logic [DATA_W-1:0] out_q   [NCH];
  logic [PD_W-1:0]   pd_q    [NCH];

  cmd_t port_cmd;
  assign port_cmd = unpack_cmd(cmd_word);

  dacreg_decode u_decode (
    .cmd_valid      (cmd_valid),
    .cmd_word       (cmd_word),
    .stage_we       (stage_we),
    .out_we         (out_we),
    .out_from_stage (out_from_stage),
    .pd_we          (pd_we),
    .pd_wake        (pd_wake),
    .data           (data),
    .pd_val         (pd_val)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    dacreg_channel u_chan (
      .clk            (clk),
      .clr_n          (clr_n),
      .stage_we       (stage_we[i]),
      .out_we         (out_we[i]),
      .out_from_stage (out_from_stage[i]),
      .pd_we          (pd_we[i]),
      .pd_wake        (pd_wake[i]),
      .data           (data),
      .pd_val         (pd_val),
      .stage_q        (stage_q[i]),
      .out_q          (out_q[i]),
      .pd_q           (pd_q[i])
    );

    // R5: a copy command moves the staging value into the output register
    a_r5_copy: assert property (@(posedge clk) disable iff (!clr_n)
      (cmd_valid && !port_cmd.pd_mode && port_cmd.op == OP_COPY)
      |=> (out_q[i] == $past(stage_q[i])));

    // R6: a broadcast loads new data into the addressed channel's output
    a_r6_broadcast_hit: assert property (@(posedge clk) disable iff (!clr_n)
      (cmd_valid && !port_cmd.pd_mode && port_cmd.op == OP_BROADCAST &&
       port_cmd.chan == i[0])
      |=> (out_q[i] == $past(cmd_word[DATA_W-1:0])));

    // R9: a power-down broadcast reaches every channel
    a_r9_pd_all: assert property (@(posedge clk) disable iff (!clr_n)
      (cmd_valid && port_cmd.pd_mode && port_cmd.op == OP_BROADCAST)
      |=> (pd_q[i] == $past(cmd_word[DATA_W-1 -: PD_W])));
  end

  assign code_a = out_q[0];
  assign code_b = out_q[1];
  assign pd_a   = pd_q[0];
  assign pd_b   = pd_q[1];

endmodule

// File: tb/dac_dual_regctl_tb.sv
`timescale 1ns/1ps
module dac_dual_regctl_tb;

  localparam real TCLK = 4.0;

  logic        clk = 1'b0;
  logic        clr_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [15:0] cmd_word = '0;
  logic [11:0] code_a, code_b;
  logic [1:0]  pd_a, pd_b;

  int n_checks = 0;
  int n_fail   = 0;

  always #(TCLK/2) clk = ~clk;

  dac_dual_regctl u_dut (
    .clk       (clk),
    .clr_n     (clr_n),
    .cmd_valid (cmd_valid),
    .cmd_word  (cmd_word),
    .code_a    (code_a),
    .code_b    (code_b),
    .pd_a      (pd_a),
    .pd_b      (pd_b)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag, input int ea, input int eb,
                         input int pa, input int pb);
    chk({tag, " code_a"}, int'(code_a), ea);
    chk({tag, " code_b"}, int'(code_b), eb);
    chk({tag, " pd_a"},   int'(pd_a),   pa);
    chk({tag, " pd_b"},   int'(pd_b),   pb);
  endtask

  // one-cycle strobe; the outputs update at the rising edge in between
  task automatic send(input logic [15:0] w);
    @(negedge clk);
    cmd_word  = w;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic t_r1_reset_state;
    #1;
    chk_all("R1 reset", 0, 0, 0, 0);
    @(negedge clk);
    clr_n = 1'b1;
  endtask

  task automatic t_r3_stage_only;
    send(16'h0123);
    chk_all("R3 stage A", 0, 0, 0, 0);
    send(16'h2456);
    chk_all("R3 stage B R7", 0, 0, 0, 0);
  endtask

  task automatic t_r5_copy;
    send(16'h8ABC);
    chk_all("R5 copy", 'h123, 'h456, 0, 0);
  endtask

  task automatic t_r4_stage_out;
    send(16'h4789);
    chk_all("R4 A R7", 'h789, 'h456, 0, 0);
    send(16'h6FFF);
    chk_all("R4 B R11 full scale", 'h789, 'hFFF, 0, 0);
  endtask

  task automatic t_r6_broadcast;
    send(16'h0111);
    send(16'hE222);
    chk_all("R6 broadcast", 'h111, 'h222, 0, 0);
  endtask

  task automatic t_r8_powerdown;
    send(16'h1400);
    chk_all("R8 pd A 1k", 'h111, 'h222, 1, 0);
    send(16'h3800);
    chk_all("R8 pd B 100k", 'h111, 'h222, 1, 2);
  endtask

  task automatic t_r10_wake;
    send(16'h8000);
    chk_all("R10 copy keeps pd", 'h111, 'h222, 1, 2);
    send(16'h0333);
    chk_all("R10 stage wakes A", 'h111, 'h222, 0, 2);
    send(16'h4444);
    chk_all("R10 R11 next cycle", 'h444, 'h222, 0, 2);
  endtask

  task automatic t_r9_pd_both;
    send(16'hDC00);
    chk_all("R9 both hiZ", 'h444, 'h222, 3, 3);
    send(16'hD000);
    chk_all("R9 both normal", 'h444, 'h222, 0, 0);
  endtask

  task automatic t_r2_ignored;
    @(negedge clk);
    cmd_word = 16'h4AAA;
    repeat (3) @(negedge clk);
    chk_all("R2 no strobe", 'h444, 'h222, 0, 0);
    send(16'h1C00);
    @(negedge clk);
    #1 clr_n = 1'b0;
    #0.5;
    chk_all("R1 async clear", 0, 0, 0, 0);
    send(16'h4555);
    chk_all("R2 strobe in clear", 0, 0, 0, 0);
    clr_n = 1'b1;
    @(negedge clk);
    chk_all("R2 after release", 0, 0, 0, 0);
    send(16'h4555);
    chk_all("R2 first strobe", 'h555, 0, 0, 0);
  endtask

  initial begin
    #(TCLK * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    t_r1_reset_state();
    t_r3_stage_only();
    t_r5_copy();
    t_r4_stage_out();
    t_r6_broadcast();
    t_r8_powerdown();
    t_r10_wake();
    t_r9_pd_both();
    t_r2_ignored();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule